// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line that rests high. A holding register sits in front of a shift register. Software can write the next byte while the current character is still being sent. When a frame ends, the waiting byte moves into the shift register at once, so consecutive frames follow with no idle gap.

All bit timing is counted in cycles of an external tick enable that runs at sixteen times the baud rate. Each frame can carry seven or eight data bits and an optional even or odd parity bit. It ends with a stop period of 7/8, one or two bit times. Two status outputs report whether the holding register can accept a byte and whether the line is still busy with a frame.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1 and `busy` is 0.
- R2: A frame starts with one low start bit, followed by the data bits least significant bit first. The start bit and every data or parity bit last 16 tick cycles each.
- R3: With `cfg_len8`=1 all eight bits of the byte are sent. With `cfg_len8`=0 only bits 6..0 are sent.
- R4: With `cfg_par_en`=1 one parity bit follows the data bits. With `cfg_par_odd`=0 the count of ones over the sent data bits plus the parity bit is even; with `cfg_par_odd`=1 it is odd.
- R5: The stop period holds the line high for 14 ticks when `cfg_stop`=00, 16 ticks when it is 01, and 32 ticks when it is 10 or 11.
- R6: A write (`wr_en`=1) stores `wr_data` in the holding register. `buf_empty` is 0 in the following cycle, and `rd_data` returns the stored byte.
- R7: When the line is idle and the holding register is full, the byte moves into the shift register on the next clock edge. In that same cycle `buf_empty` returns to 1, `busy` becomes 1 and `txd` goes low.
- R8: A byte waiting when a stop period ends is loaded on the tick that ends that stop period. Its start bit follows directly, with no idle tick, and `buf_empty` is set again.
- R9: `busy` stays 1 from the start bit until the end of the last stop period. It falls only when no byte is waiting.
- R10: A write while the holding register is full replaces the waiting byte, and only the last byte written is sent.
- R11: The data length, parity and stop settings are captured when a byte enters the shift register. Changing them during a frame does not alter that frame.
- R12: No frame timing advances in a cycle without a tick. While ticks are withheld, the line holds its current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Enable pulse at 16x the baud rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Read-back of the holding register |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_par_en | input | 1 | 1: append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_stop | input | 2 | Stop length: 00 = 7/8 bit, 01 = 1 bit, 1x = 2 bits |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding register can take a byte |
| busy | output | 1 | A frame is on the line |

## Verification
The bench records the line and the busy flag on every tick and compares them tick for tick against a frame built from the requirements. Each test uses a different pattern:
- Alternating bits (0xA5) in an 8-bit frame with no parity show whether the bits come out in the right order.
- A 7-bit frame with even parity and two stop bits shows whether bit 7 is wrongly sent and whether the parity sense is right.
- An all-zero byte with odd parity and a 7/8 stop tells the fractional stop apart from a full bit.
- A back-to-back pair with an overwritten pending byte shows the hand-off gap and which byte wins.
- A mid-frame change of the settings shows whether they are captured at load.
- A run with the ticks withheld shows that only the tick moves the frame along.

// File: rtl/sertx_pkg.sv
// Shared types and helpers for the double-buffered serial transmitter.
// Assumes the frame sequencer walks the states in declaration order.
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_t;

    localparam logic [1:0] STOP_FRAC = 2'b00;
    localparam logic [1:0] STOP_ONE  = 2'b01;

    // Parity bit for a byte; short frames ignore the top bit.
    function automatic logic par_of(input logic [7:0] d, input logic len8, input logic odd);
        logic [7:0] m;
        m = len8 ? d : {1'b0, d[6:0]};
        return (^m) ^ odd;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
// Holding register with full flag.
// Assumes a write and a hand-off in the same cycle: the write wins and
// leaves the register full with the new byte.
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    // Capture written bytes and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full && data == $past(wr_data));

    p_take_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take && !wr_en |=> !full);

endmodule

// File: rtl/sertx_seq.sv
// Frame sequencer: start bit, data LSB first, optional parity, stop period.
// Every step is gated by the 16x tick. Frame settings are latched on load.
// Assumes DW is 8, so the short length is DW-1 bits.
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pend,
    input  logic [DW-1:0] pend_data,
    input  logic          cfg_len8,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic [1:0]    cfg_stop,
    output logic          load,
    output logic          txd,
    output logic          busy
);

    localparam int CW = $clog2(2 * TPB);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] BIT_LAST  = CW'(TPB - 1);
    localparam logic [CW-1:0] FRAC_LAST = CW'((TPB * 7) / 8 - 1);
    localparam logic [CW-1:0] TWO_LAST  = CW'(2 * TPB - 1);

    tx_state_t     state;
    logic [CW-1:0] tcnt;
    logic [BW-1:0] bitn;
    logic [DW-1:0] shreg;
    logic          parb;
    logic          f_len8;
    logic          f_par;
    logic [1:0]    f_stop;
    logic [CW-1:0] stop_last;
    logic [CW-1:0] limit;
    logic [BW-1:0] last_bit;
    logic          bit_end;

    // Decode the latched stop setting into a tick limit.
    always_comb begin
        case (f_stop)
            STOP_FRAC: stop_last = FRAC_LAST;
            STOP_ONE:  stop_last = BIT_LAST;
            default:   stop_last = TWO_LAST;
        endcase
    end

    // Select the length of the current bit and detect its last tick.
    always_comb begin
        limit    = (state == ST_STOP) ? stop_last : BIT_LAST;
        last_bit = f_len8 ? BW'(DW - 1) : BW'(DW - 2);
        bit_end  = tick && (state != ST_IDLE) && (tcnt == limit);
    end

    // Hand-off from idle, or directly at the end of a stop period.
    always_comb begin
        load = pend && ((state == ST_IDLE) || (state == ST_STOP && bit_end));
    end

    // Advance the frame one tick at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            bitn   <= '0;
            shreg  <= '0;
            parb   <= 1'b0;
            f_len8 <= 1'b1;
            f_par  <= 1'b0;
            f_stop <= STOP_ONE;
        end else if (load) begin
            state  <= ST_START;
            tcnt   <= '0;
            bitn   <= '0;
            shreg  <= pend_data;
            parb   <= par_of(pend_data, cfg_len8, cfg_par_odd);
            f_len8 <= cfg_len8;
            f_par  <= cfg_par_en;
            f_stop <= cfg_stop;
        end else if (bit_end) begin
            tcnt <= '0;
            case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    shreg <= shreg >> 1;
                    bitn  <= bitn + 1'b1;
                    if (bitn == last_bit) state <= f_par ? ST_PAR : ST_STOP;
                end
                ST_PAR:  state <= ST_STOP;
                default: state <= ST_IDLE;
            endcase
        end else if (tick && state != ST_IDLE) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Line level for the current state.
    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = parb;
            default:  txd = 1'b1;
        endcase
        busy = (state != ST_IDLE);
    end

    p_load_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy && !txd);

    p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load |=> $stable(state) && $stable(tcnt) && $stable(txd));

    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick) && !$past(pend));

    p_stop_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STOP && tick && tcnt > stop_last |-> 1'b0);

endmodule

// File: rtl/sertx_dbuf.sv
// Top of the double-buffered asynchronous transmitter.
// Joins the holding register to the frame sequencer.
// Assumes tick is a single-cycle enable at 16x the baud rate.
module sertx_dbuf #(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          cfg_len8,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic [1:0]    cfg_stop,
    output logic          txd,
    output logic          buf_empty,
    output logic          busy
);

    logic hold_full;
    logic load;

    sertx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .full    (hold_full),
        .data    (rd_data)
    );

    sertx_seq #(.DW(DW), .TPB(TPB)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .pend        (hold_full),
        .pend_data   (rd_data),
        .cfg_len8    (cfg_len8),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop    (cfg_stop),
        .load        (load),
        .txd         (txd),
        .busy        (busy)
    );

    // Status output from holding occupancy.
    always_comb buf_empty = !hold_full;

    p_handoff_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load && !wr_en |=> buf_empty && busy);

endmodule

// File: tb/sertx_dbuf_test.sv
module sertx_dbuf_test;

    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 3;
    localparam int CAP = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       cfg_len8 = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'b01;
    logic       txd;
    logic       buf_empty;
    logic       busy;

    int total = 0;
    int bad = 0;
    int nt = 0;
    int ne = 0;
    logic tk_txd [CAP];
    logic tk_busy [CAP];
    logic ex [CAP];

    sertx_dbuf uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .txd(txd),
        .buf_empty(buf_empty), .busy(busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Tick generator: one pulse every TDIV clocks, changed just after the edge.
    initial begin
        int c = 0;
        forever begin
            @(posedge clk);
            #1;
            c = (c + 1) % TDIV;
            tick = tick_en && (c == 0);
        end
    end

    // Record the line and busy flag once per tick, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (tick && nt < CAP) begin
                tk_txd[nt]  = txd;
                tk_busy[nt] = busy;
                nt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic v, input int n);
        for (int k = 0; k < n; k++) begin
            ex[ne] = v;
            ne++;
        end
    endtask

    task automatic add_frame(input logic [7:0] d, input logic l8, input logic pe,
                             input logic od, input logic [1:0] sc);
        int nb;
        logic p;
        nb = l8 ? 8 : 7;
        p = od;
        push(1'b0, 16);
        for (int i = 0; i < nb; i++) begin
            push(d[i], 16);
            p = p ^ d[i];
        end
        if (pe) push(p, 16);
        push(1'b1, (sc == 2'b00) ? 14 : (sc == 2'b01) ? 16 : 32);
    endtask

    task automatic check_seq(input string req);
        int s;
        int mis;
        int first;
        s = -1;
        mis = 0;
        first = -1;
        for (int i = 0; i < nt; i++) begin
            if (s < 0 && tk_txd[i] == 1'b0) s = i;
        end
        if (s < 0 || s + ne >= nt) begin
            chk(1'b0, req, "frame not captured, samples", nt, ne);
            return;
        end
        for (int i = 0; i < ne; i++) begin
            if (tk_txd[s+i] !== ex[i] || tk_busy[s+i] !== 1'b1) begin
                mis++;
                if (first < 0) first = i;
            end
        end
        chk(mis == 0, req, "tick sequence mismatches (first at tick)", first, -1);
        chk(tk_busy[s+ne] == 1'b0 && tk_txd[s+ne] == 1'b1, req,
            "busy after last stop tick", int'(tk_busy[s+ne]), 0);
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(posedge clk);
        #1;
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4 * TDIV) @(negedge clk);
    endtask

    task automatic set_cfg(input logic l8, input logic pe, input logic od, input logic [1:0] sc);
        cfg_len8 = l8;
        cfg_par_en = pe;
        cfg_par_odd = od;
        cfg_stop = sc;
    endtask

    task automatic send_one(input logic [7:0] d, input string req);
        nt = 0;
        ne = 0;
        write_byte(d);
        chk(buf_empty == 1'b0, "R6", "buf_empty after write", int'(buf_empty), 0);
        chk(rd_data == d, "R6", "read-back", int'(rd_data), int'(d));
        @(posedge clk);
        #1;
        chk(busy && buf_empty && !txd, "R7", "hand-off busy/empty/txd",
            int'({busy, buf_empty, txd}), 6);
        add_frame(d, cfg_len8, cfg_par_en, cfg_par_odd, cfg_stop);
        wait_idle();
        check_seq(req);
    endtask

    task automatic t_reset();
        chk(txd == 1'b1, "R1", "txd at reset", int'(txd), 1);
        chk(buf_empty == 1'b1, "R1", "buf_empty at reset", int'(buf_empty), 1);
        chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
    endtask

    task automatic t_basic();
        set_cfg(1'b1, 1'b0, 1'b0, 2'b01);
        send_one(8'hA5, "R2 R3 R5 8N1");
    endtask

    task automatic t_seven_even_two();
        set_cfg(1'b0, 1'b1, 1'b0, 2'b10);
        send_one(8'hD3, "R3 R4 R5 7E2");
    endtask

    task automatic t_odd_frac();
        set_cfg(1'b1, 1'b1, 1'b1, 2'b00);
        send_one(8'h00, "R4 R5 8O-frac");
        set_cfg(1'b1, 1'b0, 1'b0, 2'b11);
        send_one(8'h5E, "R5 stop code 11");
    endtask

    task automatic t_back_to_back();
        set_cfg(1'b1, 1'b0, 1'b0, 2'b00);
        nt = 0;
        ne = 0;
        write_byte(8'h81);
        @(posedge clk);
        #1;
        write_byte(8'h42);
        chk(buf_empty == 1'b0 && busy, "R8", "pending while busy", int'(buf_empty), 0);
        write_byte(8'h9E);
        chk(rd_data == 8'h9E, "R10", "overwrite read-back", int'(rd_data), 8'h9E);
        add_frame(8'h81, 1'b1, 1'b0, 1'b0, 2'b00);
        add_frame(8'h9E, 1'b1, 1'b0, 1'b0, 2'b00);
        wait_idle();
        check_seq("R8 R9 R10 back-to-back");
        chk(buf_empty == 1'b1, "R8", "buf_empty after pair", int'(buf_empty), 1);
    endtask

    task automatic t_cfg_latch();
        set_cfg(1'b1, 1'b0, 1'b0, 2'b01);
        nt = 0;
        ne = 0;
        write_byte(8'h3C);
        repeat (40 * TDIV) @(posedge clk);
        #1;
        set_cfg(1'b0, 1'b1, 1'b1, 2'b10);
        add_frame(8'h3C, 1'b1, 1'b0, 1'b0, 2'b01);
        wait_idle();
        check_seq("R11 settings captured at load");
        set_cfg(1'b1, 1'b0, 1'b0, 2'b01);
    endtask

    task automatic t_no_tick();
        set_cfg(1'b1, 1'b0, 1'b0, 2'b01);
        tick_en = 1'b0;
        repeat (2) @(posedge clk);
        nt = 0;
        ne = 0;
        write_byte(8'hF0);
        repeat (100) @(negedge clk);
        chk(txd == 1'b0 && busy, "R12", "line held in start bit without ticks",
            int'({busy, txd}), 2);
        chk(nt == 0, "R12", "ticks seen while withheld", nt, 0);
        tick_en = 1'b1;
        add_frame(8'hF0, 1'b1, 1'b0, 1'b0, 2'b01);
        wait_idle();
        check_seq("R12 frame completes after ticks resume");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_seven_even_two();
        t_odd_frac();
        t_back_to_back();
        t_cfg_latch();
        t_no_tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule